// File: doc/BRIEF.md
# Interrupt Context Stacking Sequencer

This block saves and restores a small processor's register context on a byte-wide stack in memory. A software-trap request copies the live registers from a snapshot input and pushes them one byte per clock. Each push moves the stack pointer down by one. The block then reads a two-byte handler address from a fixed vector location and hands it back as the new program counter. A return request reads the same nine bytes back in reverse order and rebuilds every register, stack pointer included. The core presents the trigger opcode with a start strobe and reads the results on the load outputs when the done pulse appears.

The saved frame is nine bytes long. Reading upward from the final stack pointer it holds: flags, accumulator B, accumulator A, X high, X low, Y high, Y low, PC high, PC low. Because of this layout, each 16-bit register has its high byte at the lower address. The two accumulators sit in swapped order, and the flags byte is alone on top.

Top module: `ctx_stack_seq`

## Requirements
- R1: While idle, a start strobe with opcode 0x3F begins a trap sequence and one with opcode 0x0B begins a return sequence. A strobe with any other opcode is ignored: busy stays low, there is no memory access and done does not pulse.
- R2: A trap writes one byte per cycle for nine cycles, starting the cycle after acceptance. With SP0 as the snapshot stack pointer, the writes go in this order: PC low at SP0-1, PC high at SP0-2, Y low at SP0-3, Y high at SP0-4, X low at SP0-5, X high at SP0-6, A at SP0-7, B at SP0-8, flags at SP0-9.
- R3: After a trap, memory from SP0-9 upward holds flags, B, A, X high, X low, Y high, Y low, PC high, PC low.
- R4: After the pushes, a trap reads address 0xFFF6 and then 0xFFF7. It then reports PC = {byte@0xFFF6, byte@0xFFF7} and SP = SP0-9, and returns X, Y, A, B and flags unchanged from the snapshot.
- R5: A return reads SP0, SP0+1, ..., SP0+8 on consecutive cycles, starting the cycle after acceptance. It rebuilds the registers from those bytes in the R3 layout and reports SP = SP0+9.
- R6: A return after a trap restores the pre-trap PC, Y, X, A, B, flags and SP, whatever the snapshot holds at return time apart from the stack pointer.
- R7: busy is high from the cycle after acceptance until the sequence ends. Start strobes seen while busy are ignored.
- R8: done is a one-cycle pulse, and the load outputs are valid while it is high. It appears 12 clock edges after the accepting edge for a trap and 10 for a return.
- R9: Stack pointer arithmetic wraps modulo 2^16.
- R10: A synchronous active-high reset returns the block to idle with busy, done and mem_en low, even in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start strobe |
| start_op | input | 8 | Trigger opcode (0x3F trap, 0x0B return) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| snap_pc | input | 16 | Live program counter |
| snap_iy | input | 16 | Live Y index |
| snap_ix | input | 16 | Live X index |
| snap_acca | input | 8 | Live accumulator A |
| snap_accb | input | 8 | Live accumulator B |
| snap_flags | input | 8 | Live condition codes |
| snap_sp | input | 16 | Live stack pointer |
| ld_pc | output | 16 | Program counter to load |
| ld_iy | output | 16 | Y index to load |
| ld_ix | output | 16 | X index to load |
| ld_acca | output | 8 | Accumulator A to load |
| ld_accb | output | 8 | Accumulator B to load |
| ld_flags | output | 8 | Condition codes to load |
| ld_sp | output | 16 | Stack pointer to load |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after a read |

## Verification
Memory accesses start on the cycle after the accepting edge and arrive one per cycle. The bench queues every expected access, with its address and byte, before it raises the strobe. A monitor at the falling edge compares each active memory cycle against the head of that queue, so an access that is early, late, extra or out of order shows up as a mismatch. The bench counts rising edges from acceptance and checks that done appears after exactly 12 edges for a trap and 10 for a return. It reads the load outputs in that same done cycle.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  localparam int BYTE_W      = 8;
  localparam int WORD_W      = 16;
  localparam int FRAME_BYTES = 9;
  localparam int VEC_BYTES   = 2;
  localparam int IDX_W       = $clog2(FRAME_BYTES);

  typedef enum logic [3:0] {
    SL_PCH, SL_PCL, SL_YH, SL_YL, SL_XH, SL_XL, SL_ACCA, SL_ACCB, SL_FLAGS
  } slot_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH, ST_POP, ST_VEC, ST_FIN
  } seq_st_e;

  typedef struct packed {
    logic [WORD_W-1:0] pc;
    logic [WORD_W-1:0] iy;
    logic [WORD_W-1:0] ix;
    logic [BYTE_W-1:0] acca;
    logic [BYTE_W-1:0] accb;
    logic [BYTE_W-1:0] flags;
  } ctx_t;

  // Byte slot found at frame offset k above the final stack pointer.
  function automatic slot_e pop_slot(logic [IDX_W-1:0] k);
    slot_e s;
    case (k)
      4'd0:    s = SL_FLAGS;
      4'd1:    s = SL_ACCB;
      4'd2:    s = SL_ACCA;
      4'd3:    s = SL_XH;
      4'd4:    s = SL_XL;
      4'd5:    s = SL_YH;
      4'd6:    s = SL_YL;
      4'd7:    s = SL_PCH;
      default: s = SL_PCL;
    endcase
    return s;
  endfunction

  // Pushes fill the frame from the top offset downward.
  function automatic slot_e push_slot(logic [IDX_W-1:0] k);
    return pop_slot(IDX_W'(FRAME_BYTES - 1) - k);
  endfunction

  // Vector bytes arrive high first.
  function automatic slot_e vec_slot(logic [IDX_W-1:0] k);
    return (k == '0) ? SL_PCH : SL_PCL;
  endfunction

  function automatic logic [BYTE_W-1:0] get_byte(ctx_t c, slot_e s);
    logic [BYTE_W-1:0] v;
    case (s)
      SL_PCH:   v = c.pc[15:8];
      SL_PCL:   v = c.pc[7:0];
      SL_YH:    v = c.iy[15:8];
      SL_YL:    v = c.iy[7:0];
      SL_XH:    v = c.ix[15:8];
      SL_XL:    v = c.ix[7:0];
      SL_ACCA:  v = c.acca;
      SL_ACCB:  v = c.accb;
      default:  v = c.flags;
    endcase
    return v;
  endfunction

  function automatic ctx_t put_byte(ctx_t c, slot_e s, logic [BYTE_W-1:0] v);
    ctx_t r;
    r = c;
    case (s)
      SL_PCH:   r.pc[15:8] = v;
      SL_PCL:   r.pc[7:0]  = v;
      SL_YH:    r.iy[15:8] = v;
      SL_YL:    r.iy[7:0]  = v;
      SL_XH:    r.ix[15:8] = v;
      SL_XL:    r.ix[7:0]  = v;
      SL_ACCA:  r.acca     = v;
      SL_ACCB:  r.accb     = v;
      default:  r.flags    = v;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
  import ctx_pkg::*;
#(
  parameter logic [7:0] OP_TRAP   = 8'h3F,
  parameter logic [7:0] OP_RETURN = 8'h0B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_valid,
  input  logic [7:0]       start_op,
  output seq_st_e          state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             accept_o,
  output logic             push_fire_o,
  output logic             pop_fire_o,
  output logic             vec_fire_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] FRAME_LAST = IDX_W'(FRAME_BYTES - 1);
  localparam logic [IDX_W-1:0] VEC_LAST   = IDX_W'(VEC_BYTES - 1);

  seq_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             op_known;

  assign op_known    = (start_op == OP_TRAP) || (start_op == OP_RETURN);
  assign accept_o    = (st_q == ST_IDLE) && start_valid && op_known;
  assign push_fire_o = (st_q == ST_PUSH);
  assign pop_fire_o  = (st_q == ST_POP);
  assign vec_fire_o  = (st_q == ST_VEC);
  assign state_o     = st_q;
  assign idx_o       = idx_q;
  assign done_o      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (st_q == ST_FIN);
      case (st_q)
        ST_IDLE: begin
          if (accept_o) begin
            st_q  <= (start_op == OP_TRAP) ? ST_PUSH : ST_POP;
            idx_q <= '0;
          end
        end
        ST_PUSH: begin
          if (idx_q == FRAME_LAST) begin
            st_q  <= ST_VEC;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_POP: begin
          if (idx_q == FRAME_LAST) st_q <= ST_FIN;
          else                     idx_q <= idx_q + 1'b1;
        end
        ST_VEC: begin
          if (idx_q == VEC_LAST) st_q <= ST_FIN;
          else                   idx_q <= idx_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ctx_sp_unit.sv
module ctx_sp_unit #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              dec,
  input  logic              inc,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] push_addr_o
);

  logic [ADDR_W-1:0] sp_q;

  // Wraps modulo 2^ADDR_W by plain unsigned arithmetic.
  assign push_addr_o = sp_q - ADDR_W'(1);
  assign sp_o        = sp_q;

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '0;
    else if (load) sp_q <= load_val;
    else if (dec)  sp_q <= push_addr_o;
    else if (inc)  sp_q <= sp_q + ADDR_W'(1);
  end

endmodule

// File: rtl/ctx_rd_track.sv
module ctx_rd_track
  import ctx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  issue,
  input  slot_e issue_slot,
  output logic  pend_o,
  output slot_e pend_slot_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o      <= 1'b0;
      pend_slot_o <= SL_FLAGS;
    end else begin
      pend_o      <= issue;
      pend_slot_o <= issue_slot;
    end
  end

endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
  import ctx_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFF6,
  parameter logic [7:0]      OP_TRAP   = 8'h3F,
  parameter logic [7:0]      OP_RETURN = 8'h0B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_valid,
  input  logic [7:0]        start_op,
  output logic              busy,
  output logic              done,
  input  logic [15:0]       snap_pc,
  input  logic [15:0]       snap_iy,
  input  logic [15:0]       snap_ix,
  input  logic [7:0]        snap_acca,
  input  logic [7:0]        snap_accb,
  input  logic [7:0]        snap_flags,
  input  logic [ADDR_W-1:0] snap_sp,
  output logic [15:0]       ld_pc,
  output logic [15:0]       ld_iy,
  output logic [15:0]       ld_ix,
  output logic [7:0]        ld_acca,
  output logic [7:0]        ld_accb,
  output logic [7:0]        ld_flags,
  output logic [ADDR_W-1:0] ld_sp,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  seq_st_e           state;
  logic [IDX_W-1:0]  idx;
  logic              accept;
  logic              push_fire;
  logic              pop_fire;
  logic              vec_fire;
  logic [ADDR_W-1:0] sp_cur;
  logic [ADDR_W-1:0] push_addr;
  logic              rd_issue;
  slot_e             rd_issue_slot;
  logic              rd_pend;
  slot_e             rd_pend_slot;
  ctx_t              ctx_q;
  ctx_t              ctx_snap;

  ctx_seq_ctrl #(
    .OP_TRAP   (OP_TRAP),
    .OP_RETURN (OP_RETURN)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_valid (start_valid),
    .start_op    (start_op),
    .state_o     (state),
    .idx_o       (idx),
    .accept_o    (accept),
    .push_fire_o (push_fire),
    .pop_fire_o  (pop_fire),
    .vec_fire_o  (vec_fire),
    .done_o      (done)
  );

  ctx_sp_unit #(.ADDR_W(ADDR_W)) u_sp (
    .clk         (clk),
    .rst         (rst),
    .load        (accept),
    .load_val    (snap_sp),
    .dec         (push_fire),
    .inc         (pop_fire),
    .sp_o        (sp_cur),
    .push_addr_o (push_addr)
  );

  assign rd_issue      = pop_fire | vec_fire;
  assign rd_issue_slot = pop_fire ? pop_slot(idx) : vec_slot(idx);

  ctx_rd_track u_rd (
    .clk         (clk),
    .rst         (rst),
    .issue       (rd_issue),
    .issue_slot  (rd_issue_slot),
    .pend_o      (rd_pend),
    .pend_slot_o (rd_pend_slot)
  );

  assign ctx_snap = '{pc: snap_pc, iy: snap_iy, ix: snap_ix,
                      acca: snap_acca, accb: snap_accb, flags: snap_flags};

  always_ff @(posedge clk) begin
    if (rst)          ctx_q <= '0;
    else if (accept)  ctx_q <= ctx_snap;
    else if (rd_pend) ctx_q <= put_byte(ctx_q, rd_pend_slot, mem_rdata);
  end

  always_comb begin
    mem_en    = push_fire | rd_issue;
    mem_we    = push_fire;
    mem_wdata = get_byte(ctx_q, push_slot(idx));
    if (push_fire)     mem_addr = push_addr;
    else if (pop_fire) mem_addr = sp_cur;
    else               mem_addr = VEC_ADDR + ADDR_W'(idx);
  end

  assign busy     = (state != ST_IDLE);
  assign ld_pc    = ctx_q.pc;
  assign ld_iy    = ctx_q.iy;
  assign ld_ix    = ctx_q.ix;
  assign ld_acca  = ctx_q.acca;
  assign ld_accb  = ctx_q.accb;
  assign ld_flags = ctx_q.flags;
  assign ld_sp    = sp_cur;

endmodule

// File: rtl/ctx_stack_seq_chk.sv
module ctx_stack_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] ld_sp,
  input logic              accept,
  input logic              push_fire,
  input logic              pop_fire,
  input logic              vec_fire
);

  // R10: reset leaves the block idle and silent
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !mem_en && !done));

  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: done only once the sequence has ended
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7: no acceptance while busy
  a_r7_busy_no_accept: assert property (@(posedge clk) disable iff (rst)
    busy |-> !accept);

  // R2: each push moves SP down by one (wrapping, R9)
  a_r2_push_sp_step: assert property (@(posedge clk) disable iff (rst)
    push_fire |=> (ld_sp == $past(ld_sp) - ADDR_W'(1)));

  // R2: a push is a memory write
  a_r2_push_writes: assert property (@(posedge clk) disable iff (rst)
    push_fire |-> (mem_en && mem_we));

  // R5: pops read at the current SP and step it up
  a_r5_pop_at_sp: assert property (@(posedge clk) disable iff (rst)
    pop_fire |-> (mem_en && !mem_we && mem_addr == ld_sp));

  // R4: vector fetch is a read
  a_r4_vec_read: assert property (@(posedge clk) disable iff (rst)
    vec_fire |-> (mem_en && !mem_we));

  // R1: one access source at a time, and none while idle
  a_r1_one_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0({push_fire, pop_fire, vec_fire}) && (mem_en -> busy));

endmodule

bind ctx_stack_seq ctx_stack_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .ld_sp     (ld_sp),
  .accept    (accept),
  .push_fire (push_fire),
  .pop_fire  (pop_fire),
  .vec_fire  (vec_fire)
);

// File: tb/sim_ctx_stack_seq.sv
module sim_ctx_stack_seq;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1, start_valid = 1'b0;
  logic [7:0]  start_op = 8'h00;
  logic        busy, done, mem_en, mem_we;
  logic [15:0] snap_pc = 0, snap_iy = 0, snap_ix = 0, snap_sp = 0;
  logic [7:0]  snap_acca = 0, snap_accb = 0, snap_flags = 0;
  logic [15:0] ld_pc, ld_iy, ld_ix, ld_sp, mem_addr;
  logic [7:0]  ld_acca, ld_accb, ld_flags, mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  ctx_stack_seq u0 (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0] mem [int];

  typedef struct { bit we; logic [15:0] addr; logic [7:0] data; string tag; } acc_t;
  acc_t exp_q[$];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: synchronous one-byte port
  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) mem[int'(mem_addr)] = mem_wdata;
      else mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
    end

  // scoreboard monitor
  always @(negedge clk)
    if (!rst && mem_en) begin
      if (exp_q.size() == 0)
        chk(1'b0, "R1/R7 unexpected access", {7'd0, mem_we, mem_addr, mem_wdata}, 0);
      else begin
        acc_t e;
        e = exp_q.pop_front();
        chk(mem_we == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.data), e.tag,
            {7'd0, mem_we, mem_addr, mem_wdata}, {7'd0, e.we, e.addr, e.data});
      end
    end

  task automatic queue_trap(logic [15:0] sp0, pc, iy, ix, logic [7:0] a, b, f);
    logic [7:0] img [9];
    img = '{f, b, a, ix[15:8], ix[7:0], iy[15:8], iy[7:0], pc[15:8], pc[7:0]};
    for (int k = 8; k >= 0; k--)
      exp_q.push_back('{1'b1, sp0 - 16'd9 + 16'(k), img[k], "R2 push byte"});
    exp_q.push_back('{1'b0, 16'hFFF6, 8'h00, "R4 vector high read"});
    exp_q.push_back('{1'b0, 16'hFFF7, 8'h00, "R4 vector low read"});
  endtask

  task automatic queue_ret(logic [15:0] sp0);
    for (int k = 0; k < 9; k++)
      exp_q.push_back('{1'b0, sp0 + 16'(k), 8'h00, "R5 pop read"});
  endtask

  task automatic set_snap(logic [15:0] sp, pc, iy, ix, logic [7:0] a, b, f);
    snap_sp = sp; snap_pc = pc; snap_iy = iy; snap_ix = ix;
    snap_acca = a; snap_accb = b; snap_flags = f;
  endtask

  // strobe for one cycle (optionally keep strobing a return while busy),
  // then count rising edges from the accepting edge until done
  task automatic run(logic [7:0] op, int hold, output int n);
    @(negedge clk); start_valid = 1'b1; start_op = op;
    @(negedge clk); start_op = 8'h0B;
    start_valid = (hold > 0);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n >= hold) start_valid = 1'b0;
      if (done) break;
    end
  endtask

  task automatic check_regs(string tag, logic [15:0] sp, pc, iy, ix, logic [7:0] a, b, f);
    chk(ld_pc == pc, {tag, " pc"}, ld_pc, pc);
    chk(ld_iy == iy, {tag, " y"}, ld_iy, iy);
    chk(ld_ix == ix, {tag, " x"}, ld_ix, ix);
    chk({ld_acca, ld_accb, ld_flags} == {a, b, f}, {tag, " a/b/flags"},
        {ld_acca, ld_accb, ld_flags}, {a, b, f});
    chk(ld_sp == sp, {tag, " sp"}, ld_sp, sp);
  endtask

  task automatic check_frame(logic [15:0] sp0, pc, iy, ix, logic [7:0] a, b, f);
    logic [7:0] img [9];
    img = '{f, b, a, ix[15:8], ix[7:0], iy[15:8], iy[7:0], pc[15:8], pc[7:0]};
    for (int k = 0; k < 9; k++) begin
      logic [15:0] ad;
      ad = sp0 - 16'd9 + 16'(k);
      chk(mem.exists(int'(ad)) && mem[int'(ad)] == img[k], "R3 frame layout",
          mem.exists(int'(ad)) ? mem[int'(ad)] : 8'hxx, img[k]);
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    bit saw_done;
    mem[32'hFFF6] = 8'h80;
    mem[32'hFFF7] = 8'h0C;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !mem_en && ld_sp == 0, "R10 reset idle",
        {busy, done, mem_en, ld_sp}, 0);
    rst = 1'b0;

    // R1 unknown opcode ignored
    @(negedge clk); start_valid = 1'b1; start_op = 8'h00;
    @(negedge clk); start_valid = 1'b0;
    saw_done = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (busy || done) saw_done = 1;
    end
    chk(!saw_done, "R1 other opcode ignored", saw_done, 0);

    // R2 R3 R4 R8 trap
    set_snap(16'h0A00, 16'h1234, 16'h5678, 16'h9ABC, 8'h11, 8'h22, 8'hC5);
    queue_trap(16'h0A00, 16'h1234, 16'h5678, 16'h9ABC, 8'h11, 8'h22, 8'hC5);
    run(8'h3F, 0, n);
    chk(n == 12 && done, "R8 trap done timing", n, 12);
    check_regs("R4 trap result", 16'h09F7, 16'h800C, 16'h5678, 16'h9ABC, 8'h11, 8'h22, 8'hC5);
    chk(exp_q.size() == 0, "R2 all accesses seen", exp_q.size(), 0);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
    check_frame(16'h0A00, 16'h1234, 16'h5678, 16'h9ABC, 8'h11, 8'h22, 8'hC5);

    // R5 R6 return with scribbled live registers
    set_snap(16'h09F7, 16'hFFFF, 16'h0000, 16'h5555, 8'hAA, 8'h99, 8'h00);
    queue_ret(16'h09F7);
    run(8'h0B, 0, n);
    chk(n == 10 && done, "R8 return done timing", n, 10);
    check_regs("R6 restored", 16'h0A00, 16'h1234, 16'h5678, 16'h9ABC, 8'h11, 8'h22, 8'hC5);

    // R7 strobes during a trap are ignored; R9 wrap through zero
    set_snap(16'h0004, 16'hBEEF, 16'h0102, 16'hF00D, 8'h7E, 8'h81, 8'h3C);
    queue_trap(16'h0004, 16'hBEEF, 16'h0102, 16'hF00D, 8'h7E, 8'h81, 8'h3C);
    run(8'h3F, 5, n);
    chk(n == 12, "R7 busy strobes ignored", n, 12);
    check_regs("R9 wrapped trap", 16'hFFFB, 16'h800C, 16'h0102, 16'hF00D, 8'h7E, 8'h81, 8'h3C);
    check_frame(16'h0004, 16'hBEEF, 16'h0102, 16'hF00D, 8'h7E, 8'h81, 8'h3C);
    set_snap(16'hFFFB, 16'h0000, 16'hFFFF, 16'h0000, 8'h00, 8'h00, 8'hFF);
    queue_ret(16'hFFFB);
    run(8'h0B, 0, n);
    chk(n == 10, "R9 wrapped return timing", n, 10);
    check_regs("R9 wrapped restore", 16'h0004, 16'hBEEF, 16'h0102, 16'hF00D, 8'h7E, 8'h81, 8'h3C);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && !busy, "R7 no extra sequence", exp_q.size(), 0);

    // R10 reset in mid sequence
    set_snap(16'h2000, 16'h1111, 16'h2222, 16'h3333, 8'h44, 8'h55, 8'h66);
    queue_trap(16'h2000, 16'h1111, 16'h2222, 16'h3333, 8'h44, 8'h55, 8'h66);
    @(negedge clk); start_valid = 1'b1; start_op = 8'h3F;
    @(negedge clk); start_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    exp_q.delete();
    @(negedge clk);
    chk(!busy && !mem_en && !done, "R10 reset mid sequence",
        {busy, mem_en, done}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && !mem_en, "R10 stays idle", {busy, mem_en}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule